// File: doc/BRIEF.md
# Eight-Level Command-Byte Interrupt Controller

This block arbitrates up to eight interrupt levels on behalf of a processor sitting on a byte-wide register bus. Each level has a pending-request bit, an in-service bit, a mask bit and an auto-clear bit. A single byte written to the control address performs exactly one register operation: a reset, a whole-register set or clear, a set or clear of one named bit, a mode update, or a redirect of later data-port writes. Reading the control address returns a status byte carrying the winning level number and the key mode flags.

The data address reads one of four per-level registers, chosen by a two-bit field in the mode register. Writes to the data address land in the mask register, the auto-clear register or one entry of an eight-byte vector table, according to the most recent redirect command. When the group enable is on and the block is not in polled operation, any unmasked pending request raises the interrupt output. An acknowledge pulse moves the winner from pending into service, or drops it entirely when that level is set to auto-clear, and the vector output presents the table entry for the winner. Priority is fixed (level 0 highest) or rotating, where the level serviced last drops to the bottom.

Top module: `cmd_irq_ctrl`

## Requirements
- R1: After the reset input, the mask register is all ones; request, in-service, auto-clear and mode registers are zero; the status byte reads 0x80; irq_out is low. Mask bit value 1 means the level is masked.
- R2: Command 0x00 puts the request, in-service, mask, auto-clear and mode registers, the priority rotation and the write redirect back into their R1 state.
- R3: Command 00010xxx clears every request and mask bit; command 00011abc clears bit abc in both registers.
- R4: Command 00110xxx sets every mask bit; command 00111abc sets mask bit abc.
- R5: Commands 01000xxx, 01010xxx, 01001abc and 01011abc clear all request bits, set all request bits, clear request bit abc and set request bit abc.
- R6: Command 0110xxxx clears the in-service bit that ranks highest under the current priority order; 01110xxx clears all in-service bits; 01111abc clears in-service bit abc.
- R7: Command 100abcde loads mode bits 4:0. Command 1010abcd loads mode bits 6:5 with ab; cd=00 keeps mode bit 7, 01 sets it, 10 clears it, 11 leaves it unchanged.
- R8: A read at bus_sel=0 returns the in-service, mask, request or auto-clear register when mode bits 6:5 are 00, 01, 10 or 11.
- R9: Data writes go to the mask register after reset or command 0x00, to the mask after 1011xxxx, to the auto-clear register after 1100xxxx, and to vector entry abc after 11100abc.
- R10: A read at bus_sel=1 returns status: bits 2:0 the winning unmasked pending level (0 when none), bit 3 mode bit 7, bit 4 mode bit 2, bit 5 mode bit 0, bit 6 zero, bit 7 zero exactly when an unmasked request is pending.
- R11: irq_out is high when mode bit 7 is 1, mode bit 2 is 0 and an unmasked request is pending.
- R12: On int_ack with a winner pending, the winner's request bit clears and its in-service bit sets, unless its auto-clear bit is 1, in which case the in-service bit stays clear; with none pending, int_ack changes nothing. vec_out shows the winner's vector entry when mode bit 1 is 1 and entry 0 when it is 0.
- R13: With mode bit 0 clear, the lowest-numbered level wins; with it set, after level L is acknowledged the order becomes L+1 first around to L last.
- R14: An irq_src bit high at a clock edge sets its request bit at that edge, even when a command clears that bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_sel | input | 1 | 0 selects the data address, 1 the control/status address |
| bus_wdata | input | 8 | Write data or command byte |
| bus_rdata | output | 8 | Read data for the selected address (combinational) |
| irq_src | input | NLVL | Request inputs, high sets the level's request bit |
| int_ack | input | 1 | Acknowledge pulse |
| irq_out | output | 1 | Interrupt output |
| vec_out | output | VW | Vector entry for the current winner |

## Verification
The bench aims at the ordering corners: the in-service clear-top command under a rotated order, where a design that scanned from level 0 would drop the wrong bit, and the rotation base after two acknowledges, where an off-by-one would name the serviced level again. It drives the illegal mode-bit-7 code, which a careless decoder would treat as set or clear, and an acknowledge on an auto-clear level, which a wrong design would leave marked in service. It also lands a request input on the same edge as a request-clear command, where a design with the wrong precedence loses the request, and checks that command 0x00 restores the write redirect so a stale auto-clear target would show up as a mask that never changed.

// File: rtl/irc_pkg.sv
package irc_pkg;

   // Data-port write destination
   typedef enum logic [1:0] {
      TGT_MSK = 2'd0,
      TGT_ACR = 2'd1,
      TGT_MEM = 2'd2
   } irc_tgt_e;

   // Action on mode bit 7 from the high-mode command
   typedef enum logic [1:0] {
      M7_KEEP = 2'b00,
      M7_SET  = 2'b01,
      M7_CLR  = 2'b10,
      M7_BAD  = 2'b11
   } irc_m7_e;

   typedef struct packed {
      logic       rst_all;
      logic       req_clr_all;
      logic       req_set_all;
      logic       req_clr_one;
      logic       req_set_one;
      logic       msk_clr_all;
      logic       msk_set_all;
      logic       msk_clr_one;
      logic       msk_set_one;
      logic       isr_clr_all;
      logic       isr_clr_one;
      logic       isr_clr_top;
      logic       mode_lo;
      logic       mode_hi;
      irc_m7_e    m7;
      logic       to_msk;
      logic       to_acr;
      logic       to_mem;
      logic [2:0] idx;
      logic [4:0] lo5;
      logic [1:0] hi2;
   } irc_cmd_t;

   localparam int unsigned BUS_W = 8;

endpackage

// File: rtl/irc_cmd_dec.sv
module irc_cmd_dec
   import irc_pkg::*;
(
   input  logic [BUS_W-1:0] code,
   output irc_cmd_t         cmd
);

   always_comb begin
      cmd     = '0;
      cmd.idx = code[2:0];
      cmd.lo5 = code[4:0];
      cmd.hi2 = code[3:2];
      cmd.m7  = irc_m7_e'(code[1:0]);
      casez (code)
         8'b0000_0000: cmd.rst_all = 1'b1;
         8'b0001_0???: begin
            cmd.req_clr_all = 1'b1;
            cmd.msk_clr_all = 1'b1;
         end
         8'b0001_1???: begin
            cmd.req_clr_one = 1'b1;
            cmd.msk_clr_one = 1'b1;
         end
         8'b0011_0???: cmd.msk_set_all = 1'b1;
         8'b0011_1???: cmd.msk_set_one = 1'b1;
         8'b0100_0???: cmd.req_clr_all = 1'b1;
         8'b0100_1???: cmd.req_clr_one = 1'b1;
         8'b0101_0???: cmd.req_set_all = 1'b1;
         8'b0101_1???: cmd.req_set_one = 1'b1;
         8'b0110_????: cmd.isr_clr_top = 1'b1;
         8'b0111_0???: cmd.isr_clr_all = 1'b1;
         8'b0111_1???: cmd.isr_clr_one = 1'b1;
         8'b100?_????: cmd.mode_lo     = 1'b1;
         8'b1010_????: cmd.mode_hi     = 1'b1;
         8'b1011_????: cmd.to_msk      = 1'b1;
         8'b1100_????: cmd.to_acr      = 1'b1;
         8'b1110_0???: cmd.to_mem      = 1'b1;
         default:      ;
      endcase
   end

endmodule

// File: rtl/irc_prio_pick.sv
module irc_prio_pick #(
   parameter int unsigned N      = 8,
   parameter bit          ROTATE = 1'b1,
   parameter int unsigned LW     = $clog2(N)
) (
   input  logic [N-1:0]  vec,
   input  logic [LW-1:0] base,
   output logic          any,
   output logic [LW-1:0] idx
);

   assign any = |vec;

   generate
      if (ROTATE) begin : g_rot
         // Scan from base upward with power-of-two wrap; last hit kept is the first in order
         always_comb begin
            logic [LW-1:0] pos;
            idx = '0;
            pos = '0;
            for (int k = int'(N) - 1; k >= 0; k--) begin
               pos = base + LW'(k);
               if (vec[pos]) idx = pos;
            end
         end
      end else begin : g_fix
         logic unused_base;
         assign unused_base = ^base;
         always_comb begin
            idx = '0;
            for (int k = int'(N) - 1; k >= 0; k--) begin
               if (vec[k]) idx = LW'(k);
            end
         end
      end
   endgenerate

   // R13
   always_comb begin
      if (any) begin
         pick_hit_chk: assert (vec[idx]);
      end
   end

endmodule

// File: rtl/irc_vec_mem.sv
module irc_vec_mem #(
   parameter int unsigned N  = 8,
   parameter int unsigned VW = 8,
   parameter int unsigned AW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [VW-1:0] wd,
   input  logic [AW-1:0] ra,
   output logic [VW-1:0] rd
);

   logic [VW-1:0] ent_q [N];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(N); i++) ent_q[i] <= '0;
      end else if (we) begin
         ent_q[wa] <= wd;
      end
   end

   assign rd = ent_q[ra];

endmodule

// File: rtl/cmd_irq_ctrl.sv
module cmd_irq_ctrl
   import irc_pkg::*;
#(
   parameter int unsigned NLVL      = 8,
   parameter int unsigned VW        = 8,
   parameter bit          ROTATE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic             bus_sel,
   input  logic [7:0]       bus_wdata,
   output logic [7:0]       bus_rdata,
   input  logic [NLVL-1:0]  irq_src,
   input  logic             int_ack,
   output logic             irq_out,
   output logic [VW-1:0]    vec_out
);

   localparam int unsigned LW        = $clog2(NLVL);
   localparam logic [LW-1:0] LAST_INIT = LW'(NLVL - 1);

   // Elaboration checks
   generate
      if (NLVL < 2 || NLVL > 8 || (NLVL & (NLVL - 1)) != 0) begin : g_bad_nlvl
         $error("NLVL must be a power of two from 2 to 8");
      end
      if (VW < 1 || VW > BUS_W) begin : g_bad_vw
         $error("VW must be from 1 to the bus width");
      end
   endgenerate

   // State
   logic [NLVL-1:0] req_q, isr_q, msk_q, acr_q;
   logic [NLVL-1:0] req_d, isr_d, msk_d, acr_d;
   logic [7:0]      mode_q, mode_d;
   irc_tgt_e        tgt_q, tgt_d;
   logic [LW-1:0]   mix_q, mix_d;
   logic [LW-1:0]   last_q, last_d;

   // Command decode
   irc_cmd_t        cmd;
   logic            cmd_wr, dat_wr;
   logic            idx_ok;
   logic [LW-1:0]   bit_i;

   assign cmd_wr = bus_wr &  bus_sel;
   assign dat_wr = bus_wr & ~bus_sel;

   irc_cmd_dec u_dec (
      .code (bus_wdata),
      .cmd  (cmd)
   );

   assign idx_ok = (int'(cmd.idx) < int'(NLVL));
   assign bit_i  = cmd.idx[LW-1:0];

   // Priority
   logic            rot_on;
   logic [LW-1:0]   base;
   logic [NLVL-1:0] pend_vec;
   logic            pend_any, isr_any;
   logic [LW-1:0]   pend_idx, isr_idx;

   assign rot_on   = ROTATE_EN && mode_q[0];
   assign base     = rot_on ? LW'(last_q + 1'b1) : '0;
   assign pend_vec = req_q & ~msk_q;

   irc_prio_pick #(.N(NLVL), .ROTATE(ROTATE_EN)) u_pick_pend (
      .vec  (pend_vec),
      .base (base),
      .any  (pend_any),
      .idx  (pend_idx)
   );

   irc_prio_pick #(.N(NLVL), .ROTATE(ROTATE_EN)) u_pick_isr (
      .vec  (isr_q),
      .base (base),
      .any  (isr_any),
      .idx  (isr_idx)
   );

   // Next state: acknowledge, then bus write, then request inputs
   always_comb begin
      req_d  = req_q;
      isr_d  = isr_q;
      msk_d  = msk_q;
      acr_d  = acr_q;
      mode_d = mode_q;
      tgt_d  = tgt_q;
      mix_d  = mix_q;
      last_d = last_q;

      if (int_ack && pend_any) begin
         req_d[pend_idx] = 1'b0;
         if (!acr_q[pend_idx]) isr_d[pend_idx] = 1'b1;
         if (rot_on) last_d = pend_idx;
      end

      if (cmd_wr) begin
         if (cmd.rst_all) begin
            req_d  = '0;
            isr_d  = '0;
            msk_d  = '1;
            acr_d  = '0;
            mode_d = '0;
            tgt_d  = TGT_MSK;
            mix_d  = '0;
            last_d = LAST_INIT;
         end
         if (cmd.req_clr_all) req_d = '0;
         if (cmd.req_set_all) req_d = '1;
         if (cmd.msk_clr_all) msk_d = '0;
         if (cmd.msk_set_all) msk_d = '1;
         if (cmd.isr_clr_all) isr_d = '0;
         if (idx_ok) begin
            if (cmd.req_clr_one) req_d[bit_i] = 1'b0;
            if (cmd.req_set_one) req_d[bit_i] = 1'b1;
            if (cmd.msk_clr_one) msk_d[bit_i] = 1'b0;
            if (cmd.msk_set_one) msk_d[bit_i] = 1'b1;
            if (cmd.isr_clr_one) isr_d[bit_i] = 1'b0;
         end
         if (cmd.isr_clr_top && isr_any) isr_d[isr_idx] = 1'b0;
         if (cmd.mode_lo) mode_d[4:0] = cmd.lo5;
         if (cmd.mode_hi) begin
            mode_d[6:5] = cmd.hi2;
            case (cmd.m7)
               M7_SET:  mode_d[7] = 1'b1;
               M7_CLR:  mode_d[7] = 1'b0;
               default: ;
            endcase
         end
         if (cmd.to_msk) tgt_d = TGT_MSK;
         if (cmd.to_acr) tgt_d = TGT_ACR;
         if (cmd.to_mem && idx_ok) begin
            tgt_d = TGT_MEM;
            mix_d = bit_i;
         end
      end

      if (dat_wr) begin
         case (tgt_q)
            TGT_MSK: msk_d = bus_wdata[NLVL-1:0];
            TGT_ACR: acr_d = bus_wdata[NLVL-1:0];
            default: ;
         endcase
      end

      req_d = req_d | irq_src;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= '0;
         isr_q  <= '0;
         msk_q  <= '1;
         acr_q  <= '0;
         mode_q <= '0;
         tgt_q  <= TGT_MSK;
         mix_q  <= '0;
         last_q <= LAST_INIT;
      end else begin
         req_q  <= req_d;
         isr_q  <= isr_d;
         msk_q  <= msk_d;
         acr_q  <= acr_d;
         mode_q <= mode_d;
         tgt_q  <= tgt_d;
         mix_q  <= mix_d;
         last_q <= last_d;
      end
   end

   // Vector table
   logic            mem_we;
   logic [LW-1:0]   mem_ra;

   assign mem_we = dat_wr && (tgt_q == TGT_MEM);
   assign mem_ra = mode_q[1] ? pend_idx : '0;

   irc_vec_mem #(.N(NLVL), .VW(VW)) u_vmem (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (mem_we),
      .wa    (mix_q),
      .wd    (bus_wdata[VW-1:0]),
      .ra    (mem_ra),
      .rd    (vec_out)
   );

   // Read path
   logic [7:0] sts;
   logic [7:0] dat_rd;

   always_comb begin
      sts    = '0;
      sts[2:0] = pend_any ? 3'(pend_idx) : 3'd0;
      sts[3] = mode_q[7];
      sts[4] = mode_q[2];
      sts[5] = mode_q[0];
      sts[7] = ~pend_any;
      dat_rd = '0;
      case (mode_q[6:5])
         2'b00:   dat_rd[NLVL-1:0] = isr_q;
         2'b01:   dat_rd[NLVL-1:0] = msk_q;
         2'b10:   dat_rd[NLVL-1:0] = req_q;
         default: dat_rd[NLVL-1:0] = acr_q;
      endcase
   end

   assign bus_rdata = bus_sel ? sts : dat_rd;
   assign irq_out   = mode_q[7] & ~mode_q[2] & pend_any;

   // Assertions

   // R2
   rst_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && bus_wdata == 8'h00 && irq_src == '0)
      |=> (msk_q == '1 && req_q == '0 && isr_q == '0 && acr_q == '0
           && mode_q == '0 && tgt_q == TGT_MSK));

   // R7
   m7_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && bus_wdata[7:4] == 4'b1010 && bus_wdata[1:0] == 2'b11)
      |=> (mode_q[7] == $past(mode_q[7])));

   // R12
   ack_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int_ack && pend_any && !bus_wr && irq_src == '0 && !acr_q[pend_idx])
      |=> (isr_q[$past(pend_idx)] && !req_q[$past(pend_idx)]));

   // R12
   ack_auto_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int_ack && pend_any && !bus_wr && acr_q[pend_idx] && !isr_q[pend_idx])
      |=> !isr_q[$past(pend_idx)]);

   // R6
   isr_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && cmd.isr_clr_top && isr_any && !int_ack)
      |=> !isr_q[$past(isr_idx)]);

   // R10
   sts_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_rdata[7]) |-> pend_vec[bus_rdata[LW-1:0]]);

   // R14
   src_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_src != '0) |=> ((req_q & $past(irq_src)) == $past(irq_src)));

endmodule

// File: tb/cmd_irq_ctrl_test.sv
`timescale 1ns/1ps
module cmd_irq_ctrl_test;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       bus_wr;
   logic       bus_sel;
   logic [7:0] bus_wdata;
   logic [7:0] bus_rdata;
   logic [7:0] irq_src;
   logic       int_ack;
   logic       irq_out;
   logic [7:0] vec_out;

   int n_run  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   cmd_irq_ctrl uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_sel   (bus_sel),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_src   (irq_src),
      .int_ack   (int_ack),
      .irq_out   (irq_out),
      .vec_out   (vec_out)
   );

   task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic cmd(input logic [7:0] b);
      @(negedge clk);
      bus_wr = 1'b1; bus_sel = 1'b1; bus_wdata = b;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic dat(input logic [7:0] b);
      @(negedge clk);
      bus_wr = 1'b1; bus_sel = 1'b0; bus_wdata = b;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic ack();
      @(negedge clk);
      int_ack = 1'b1;
      @(negedge clk);
      int_ack = 1'b0;
   endtask

   task automatic rd_sts(output logic [7:0] v);
      bus_sel = 1'b1;
      #1;
      v = bus_rdata;
   endtask

   // which: 00 in-service, 01 mask, 10 request, 11 auto-clear
   task automatic rd_reg(input logic [1:0] which, output logic [7:0] v);
      cmd({4'b1010, which, 2'b00});
      bus_sel = 1'b0;
      #1;
      v = bus_rdata;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      rd_sts(v);              chk("R1 status", v, 8'h80);
      chk("R1 irq_out", {7'd0, irq_out}, 8'h00);
      bus_sel = 1'b0; #1;     chk("R1/R8 isr sel00", bus_rdata, 8'h00);
      rd_reg(2'b01, v);       chk("R1/R8 mask sel01", v, 8'hFF);
      rd_reg(2'b10, v);       chk("R1/R8 req sel10", v, 8'h00);
      rd_reg(2'b11, v);       chk("R1/R8 acr sel11", v, 8'h00);
   endtask

   task automatic t_req_cmds();
      logic [7:0] v;
      cmd(8'h00);
      cmd(8'h5B); rd_reg(2'b10, v); chk("R5 set bit3", v, 8'h08);
      rd_sts(v);                    chk("R10 all masked", v, 8'h80);
      cmd(8'h50); rd_reg(2'b10, v); chk("R5 set all", v, 8'hFF);
      cmd(8'h49); rd_reg(2'b10, v); chk("R5 clr bit1", v, 8'hFD);
      cmd(8'h40); rd_reg(2'b10, v); chk("R5 clr all", v, 8'h00);
   endtask

   task automatic t_mask_cmds();
      logic [7:0] v;
      cmd(8'h00);
      cmd(8'h50);
      cmd(8'h1A);
      rd_reg(2'b10, v); chk("R3 req bit2 cleared", v, 8'hFB);
      rd_reg(2'b01, v); chk("R3 mask bit2 cleared", v, 8'hFB);
      rd_sts(v);        chk("R3 nothing pending", v, 8'h80);
      cmd(8'h10);
      rd_reg(2'b10, v); chk("R3 req all cleared", v, 8'h00);
      rd_reg(2'b01, v); chk("R3 mask all cleared", v, 8'h00);
      cmd(8'h3D); rd_reg(2'b01, v); chk("R4 set mask bit5", v, 8'h20);
      cmd(8'h30); rd_reg(2'b01, v); chk("R4 set mask all", v, 8'hFF);
   endtask

   task automatic t_status();
      logic [7:0] v;
      cmd(8'h00); cmd(8'h10); cmd(8'hA1);
      cmd(8'h5D); cmd(8'h5B);
      rd_sts(v); chk("R10 winner 3", v, 8'h0B);
      chk("R11 irq high", {7'd0, irq_out}, 8'h01);
      cmd(8'h84);
      rd_sts(v); chk("R10 polled flag", v, 8'h1B);
      chk("R11 polled irq low", {7'd0, irq_out}, 8'h00);
      cmd(8'h80);
      chk("R11 irq back", {7'd0, irq_out}, 8'h01);
      cmd(8'hA2);
      rd_sts(v); chk("R7 bit7 cleared", v, 8'h03);
      chk("R11 group off", {7'd0, irq_out}, 8'h00);
      cmd(8'hA3);
      rd_sts(v); chk("R7 illegal keeps 0", v, 8'h03);
      cmd(8'hA1);
      cmd(8'hA3);
      rd_sts(v); chk("R7 illegal keeps 1", v, 8'h0B);
      cmd(8'h3B);
      rd_sts(v); chk("R4/R10 masked 3 winner 5", v, 8'h0D);
      cmd(8'h95);
      rd_sts(v); chk("R7 low5 load, bit7 kept", v, 8'h3D);
   endtask

   task automatic t_redirect();
      logic [7:0] v;
      cmd(8'h00);
      dat(8'h5A); rd_reg(2'b01, v); chk("R9 default to mask", v, 8'h5A);
      cmd(8'hC0); dat(8'h0F);
      rd_reg(2'b11, v); chk("R9 to acr", v, 8'h0F);
      rd_reg(2'b01, v); chk("R9 mask untouched", v, 8'h5A);
      cmd(8'hB0); dat(8'h33);
      rd_reg(2'b01, v); chk("R9 back to mask", v, 8'h33);
      cmd(8'hC0); cmd(8'h00); dat(8'h11);
      rd_reg(2'b01, v); chk("R2/R9 reset restores mask target", v, 8'h11);
      rd_reg(2'b11, v); chk("R2 acr cleared", v, 8'h00);
   endtask

   task automatic t_ack();
      logic [7:0] v;
      cmd(8'h00); cmd(8'h10); cmd(8'hA1); cmd(8'h82);
      for (int i = 0; i < 8; i++) begin
         cmd(8'hE0 | 8'(i));
         dat(8'h40 + 8'(i));
      end
      cmd(8'h5A); cmd(8'h5D); cmd(8'h5E);
      rd_sts(v); chk("R13 fixed winner 2", v, 8'h0A);
      chk("R12 vec winner 2", vec_out, 8'h42);
      ack();
      rd_reg(2'b10, v); chk("R12 req after ack", v, 8'h60);
      rd_reg(2'b00, v); chk("R12 isr after ack", v, 8'h04);
      chk("R12 vec winner 5", vec_out, 8'h45);
      cmd(8'h80);
      chk("R12 single vector", vec_out, 8'h40);
      cmd(8'h82);
      cmd(8'hC0); dat(8'h20);
      ack();
      rd_reg(2'b10, v); chk("R12 autoclear req", v, 8'h40);
      rd_reg(2'b00, v); chk("R12 autoclear isr", v, 8'h04);
      cmd(8'h40);
      ack();
      rd_reg(2'b00, v); chk("R12 idle ack isr", v, 8'h04);
      rd_reg(2'b10, v); chk("R12 idle ack req", v, 8'h00);
      // in-service commands
      dat(8'h00);
      cmd(8'h59); cmd(8'h5C); cmd(8'h5F);
      ack(); ack(); ack();
      rd_reg(2'b00, v); chk("R12 three in service", v, 8'h96);
      cmd(8'h60); rd_reg(2'b00, v); chk("R6 clear top fixed", v, 8'h94);
      cmd(8'h7F); rd_reg(2'b00, v); chk("R6 clear bit7", v, 8'h14);
      cmd(8'h70); rd_reg(2'b00, v); chk("R6 clear all", v, 8'h00);
   endtask

   task automatic t_rotate();
      logic [7:0] v;
      cmd(8'h00); cmd(8'h10); cmd(8'hA1); cmd(8'h81);
      cmd(8'h58); cmd(8'h5B); cmd(8'h5E);
      rd_sts(v); chk("R13 rot first 0", v, 8'h28);
      ack();
      rd_sts(v); chk("R13 rot after 0 -> 3", v, 8'h2B);
      ack();
      rd_sts(v); chk("R13 rot after 3 -> 6", v, 8'h2E);
      cmd(8'h58); cmd(8'h5C);
      rd_sts(v); chk("R13 rot base 4", v, 8'h2C);
      cmd(8'h60);
      rd_reg(2'b00, v); chk("R6 clear top rotated", v, 8'h08);
      cmd(8'h00);
      rd_sts(v);        chk("R2 status", v, 8'h80);
      rd_reg(2'b01, v); chk("R2 mask", v, 8'hFF);
      rd_reg(2'b10, v); chk("R2 req", v, 8'h00);
      rd_reg(2'b00, v); chk("R2 isr", v, 8'h00);
      cmd(8'h10); cmd(8'hA1);
      cmd(8'h5B); cmd(8'h5E);
      rd_sts(v); chk("R2/R13 fixed after reset cmd", v, 8'h0B);
   endtask

   task automatic t_src();
      logic [7:0] v;
      cmd(8'h00);
      cmd(8'h59);
      @(negedge clk);
      bus_wr = 1'b1; bus_sel = 1'b1; bus_wdata = 8'h40; irq_src = 8'h40;
      @(negedge clk);
      bus_wr = 1'b0; irq_src = 8'h00;
      rd_reg(2'b10, v); chk("R14 src beats clear", v, 8'h40);
      @(negedge clk); irq_src = 8'h04;
      @(negedge clk); irq_src = 8'h00;
      rd_reg(2'b10, v); chk("R14 src pulse", v, 8'h44);
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; bus_wr = 1'b0; bus_sel = 1'b0; bus_wdata = '0;
      irq_src = '0; int_ack = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_req_cmds();
      t_mask_cmds();
      t_status();
      t_redirect();
      t_ack();
      t_rotate();
      t_src();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule